// File: doc/BRIEF.md
# Scintillator Bar Multiplicity Trigger

This block watches hit bits from two layers of scintillator bars, an upper and a lower layer of 64 bars each. A selectable mode merges them into one 64-bit bar bus. The mode can take one layer alone, the union of both layers, or only the bars hit in both layers. Any set bit on the merged bus drives a combinational grand-OR output.

The block issues a trigger when enough distinct bars fire within a short time. It must first see a quiet period with no hits on the merged bus. The first hit after that period opens a collection window of programmable length, counted in clock cycles. Every bar seen inside the window is recorded once. When the number of distinct bars reaches the programmed minimum, a one-cycle trigger pulse is issued. After the window closes, a new quiet period must pass before the block can trigger again.

The configuration inputs are copied into internal registers only while the block is idle. A change made while a window is open therefore waits until that window has closed.

Top module: `scint_mult_trig`

## Requirements
- R1: `barMode` selects the merged bus: 0 takes the lower layer only, 1 takes the upper layer only, 2 takes the bitwise OR of both layers, and 3 takes the bitwise AND of both layers. Bit i of each hit input and of the merged bus is bar i.
- R2: `grandOr` is high in the same cycle as the hit inputs whenever any bit of the merged bus is set, and low otherwise.
- R3: The block is armed only after `emptyLen` consecutive cycles with an all-zero merged bus (a setting of 0 counts as 1). A hit before then restarts the count. The count starts from zero after reset and again after every window.
- R4: An armed hit opens a window. The window lasts `multWindowLen` cycles, counting the opening cycle (a setting of 0 counts as 1). Hits in later cycles are not part of the window.
- R5: The multiplicity is the number of distinct bars seen on the merged bus during the window. A bar hit in several cycles counts once.
- R6: `multTrig` is a one-cycle pulse in the cycle after the window cycle in which the multiplicity first reaches `minMult`. It fires at most once per window, and it cannot fire again until the window has ended and a new quiet period has passed.
- R7: If the window closes with the multiplicity below `minMult`, no trigger is issued and the block goes back to waiting for a quiet period.
- R8: The configuration inputs are captured only in idle cycles that do not open a window. Changes made while a window is open have no effect on that window and apply after it closes.
- R9: During and right after reset, `multTrig` is low and no window is open. The internal settings start at OR mode, minimum 2, and both lengths 80, until the first idle cycle loads the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trigger clock |
| rstN | input | 1 | Active-low synchronous reset |
| topHits | input | 64 | Upper layer bar hits |
| botHits | input | 64 | Lower layer bar hits |
| barMode | input | 2 | Layer combining mode |
| minMult | input | 7 | Minimum distinct-bar count for a trigger |
| multWindowLen | input | 16 | Collection window length in cycles |
| emptyLen | input | 16 | Required quiet period in cycles |
| grandOr | output | 1 | Any merged bar hit |
| multTrig | output | 1 | Multiplicity trigger pulse |

## Verification
A table of layer patterns goes through every combining mode. It includes patterns that light only the layer a mode ignores, and overlapping and disjoint pairs for the AND mode, so a swapped or wrong mode shows up on both `grandOr` and the trigger. Directed sequences repeat one bar across several cycles to separate distinct counting from hit counting. They also place the deciding hit on the last window cycle and on the first cycle after it, to pin down the window edge. Other sequences hit before the quiet period ends, fire twice within one window, and change the minimum mid-window, to separate arming, one-shot and configuration-freeze faults.

// File: rtl/scint_trig_pkg.sv
package scint_trig_pkg;

  typedef enum logic [1:0] {
    SEL_BOT = 2'd0,
    SEL_TOP = 2'd1,
    SEL_OR  = 2'd2,
    SEL_AND = 2'd3
  } barSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic startWin;
    logic stepWin;
    logic endWin;
    logic emptyRun;
  } ctrlStb_t;

endpackage

// File: rtl/scint_trig_dp.sv
module scint_trig_dp
  import scint_trig_pkg::*;
#(
  parameter int NUM_BARS      = 64,
  parameter int WIN_W         = 16,
  parameter int CNT_W         = $clog2(NUM_BARS + 1),
  parameter int DEF_MIN       = 2,
  parameter int DEF_MULT_WIN  = 80,
  parameter int DEF_EMPTY_WIN = 80
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_BARS-1:0] topHits,
  input  logic [NUM_BARS-1:0] botHits,
  input  logic [1:0]          modeIn,
  input  logic [CNT_W-1:0]    minIn,
  input  logic [WIN_W-1:0]    multWinIn,
  input  logic [WIN_W-1:0]    emptyWinIn,
  input  ctrlStb_t            stb,
  output logic                grandOr,
  output logic                armed,
  output logic                fireOk,
  output logic                winDone,
  output logic [CNT_W-1:0]    cfgMin,
  output logic [WIN_W-1:0]    cfgMultWin,
  output logic [WIN_W-1:0]    winCnt
);

  logic [1:0]          cfgMode;
  logic [WIN_W-1:0]    cfgEmptyWin;
  logic [WIN_W-1:0]    effEmpty;
  logic [WIN_W-1:0]    emptyCnt;
  logic [NUM_BARS-1:0] barBus;
  logic [NUM_BARS-1:0] seenBars;
  logic [NUM_BARS-1:0] unionBars;
  logic [CNT_W-1:0]    hitCount;
  logic [WIN_W:0]      winNext;

  // per-bar layer combining
  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    assign barBus[b] = (cfgMode == SEL_BOT) ? botHits[b] :
                       (cfgMode == SEL_TOP) ? topHits[b] :
                       (cfgMode == SEL_OR)  ? (topHits[b] | botHits[b]) :
                                              (topHits[b] & botHits[b]);
  end

  assign grandOr   = |barBus;
  assign unionBars = seenBars | barBus;

  always_comb begin
    hitCount = '0;
    for (int i = 0; i < NUM_BARS; i++) hitCount = hitCount + CNT_W'(unionBars[i]);
  end

  assign fireOk   = hitCount >= cfgMin;
  assign winNext  = {1'b0, winCnt} + 1'b1;
  assign winDone  = winNext >= {1'b0, cfgMultWin};
  assign effEmpty = (cfgEmptyWin == '0) ? WIN_W'(1) : cfgEmptyWin;
  assign armed    = emptyCnt >= effEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMode     <= SEL_OR;
      cfgMin      <= CNT_W'(DEF_MIN);
      cfgMultWin  <= WIN_W'(DEF_MULT_WIN);
      cfgEmptyWin <= WIN_W'(DEF_EMPTY_WIN);
    end else if (stb.loadCfg) begin
      cfgMode     <= modeIn;
      cfgMin      <= minIn;
      cfgMultWin  <= multWinIn;
      cfgEmptyWin <= emptyWinIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emptyCnt <= '0;
    end else if (stb.emptyRun) begin
      if (!armed) emptyCnt <= emptyCnt + 1'b1;
    end else begin
      emptyCnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenBars <= '0;
      winCnt   <= '0;
    end else if (stb.endWin) begin
      seenBars <= '0;
      winCnt   <= '0;
    end else if (stb.startWin) begin
      seenBars <= barBus;
      winCnt   <= WIN_W'(1);
    end else if (stb.stepWin) begin
      seenBars <= unionBars;
      winCnt   <= winNext[WIN_W-1:0];
    end
  end

endmodule

// File: rtl/scint_trig_ctrl.sv
module scint_trig_ctrl
  import scint_trig_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     anyHit,
  input  logic     armed,
  input  logic     fireOk,
  input  logic     winDone,
  output ctrlStb_t stb,
  output logic     multTrig,
  output logic     inWindow
);

  typedef enum logic [1:0] {ST_IDLE, ST_OPEN, ST_HOLD} ctrlState_e;

  ctrlState_e state, nextState;
  logic       trigNext;

  always_comb begin
    stb       = '0;
    nextState = state;
    trigNext  = 1'b0;
    case (state)
      ST_IDLE: begin
        stb.emptyRun = !anyHit;
        if (armed && anyHit) begin
          stb.startWin = 1'b1;
          trigNext     = fireOk;
          if (winDone) stb.endWin = 1'b1;
          else         nextState  = fireOk ? ST_HOLD : ST_OPEN;
        end else begin
          stb.loadCfg = 1'b1;
        end
      end
      ST_OPEN: begin
        stb.stepWin = 1'b1;
        trigNext    = fireOk;
        if (winDone) begin
          stb.endWin = 1'b1;
          nextState  = ST_IDLE;
        end else if (fireOk) begin
          nextState = ST_HOLD;
        end
      end
      default: begin
        stb.stepWin = 1'b1;
        if (winDone) begin
          stb.endWin = 1'b1;
          nextState  = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      multTrig <= 1'b0;
    end else begin
      state    <= nextState;
      multTrig <= trigNext;
    end
  end

  assign inWindow = state != ST_IDLE;

endmodule

// File: rtl/scint_mult_trig.sv
module scint_mult_trig
  import scint_trig_pkg::*;
#(
  parameter int NUM_BARS      = 64,
  parameter int WIN_W         = 16,
  parameter int DEF_MIN       = 2,
  parameter int DEF_MULT_WIN  = 80,
  parameter int DEF_EMPTY_WIN = 80,
  localparam int CNT_W        = $clog2(NUM_BARS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_BARS-1:0] topHits,
  input  logic [NUM_BARS-1:0] botHits,
  input  logic [1:0]          barMode,
  input  logic [CNT_W-1:0]    minMult,
  input  logic [WIN_W-1:0]    multWindowLen,
  input  logic [WIN_W-1:0]    emptyLen,
  output logic                grandOr,
  output logic                multTrig
);

  ctrlStb_t         stb;
  logic             armed;
  logic             fireOk;
  logic             winDone;
  logic             inWindow;
  logic [CNT_W-1:0] cfgMin;
  logic [WIN_W-1:0] cfgMultWin;
  logic [WIN_W-1:0] winCnt;

  scint_trig_dp #(
    .NUM_BARS(NUM_BARS), .WIN_W(WIN_W), .CNT_W(CNT_W),
    .DEF_MIN(DEF_MIN), .DEF_MULT_WIN(DEF_MULT_WIN), .DEF_EMPTY_WIN(DEF_EMPTY_WIN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .topHits(topHits), .botHits(botHits),
    .modeIn(barMode), .minIn(minMult), .multWinIn(multWindowLen), .emptyWinIn(emptyLen),
    .stb(stb), .grandOr(grandOr), .armed(armed), .fireOk(fireOk), .winDone(winDone),
    .cfgMin(cfgMin), .cfgMultWin(cfgMultWin), .winCnt(winCnt)
  );

  scint_trig_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .anyHit(grandOr), .armed(armed), .fireOk(fireOk),
    .winDone(winDone), .stb(stb), .multTrig(multTrig), .inWindow(inWindow)
  );

endmodule

// File: rtl/scint_mult_trig_chk.sv
module scint_mult_trig_chk #(
  parameter int NUM_BARS = 64,
  parameter int WIN_W    = 16,
  parameter int CNT_W    = 7
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_BARS-1:0] topHits,
  input logic [NUM_BARS-1:0] botHits,
  input logic                grandOr,
  input logic                multTrig,
  input logic                inWindow,
  input logic [CNT_W-1:0]    cfgMin,
  input logic [WIN_W-1:0]    cfgMultWin,
  input logic [WIN_W-1:0]    winCnt
);

  // R2
  grandor_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (topHits == '0 && botHits == '0) |-> !grandOr);

  // R6
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    multTrig |=> !multTrig);

  // R6
  trig_after_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    multTrig |-> $past(grandOr));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    inWindow |=> ($stable(cfgMin) && $stable(cfgMultWin)));

  // R4
  win_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    inWindow |-> (winCnt != '0 && winCnt < cfgMultWin));

endmodule

bind scint_mult_trig scint_mult_trig_chk #(
  .NUM_BARS(NUM_BARS), .WIN_W(WIN_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .topHits(topHits), .botHits(botHits),
  .grandOr(grandOr), .multTrig(multTrig), .inWindow(inWindow),
  .cfgMin(cfgMin), .cfgMultWin(cfgMultWin), .winCnt(winCnt)
);

// File: tb/scint_mult_trig_tb_top.sv
module scint_mult_trig_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] topHits = '0;
  logic [63:0] botHits = '0;
  logic [1:0]  barMode = 2'd2;
  logic [6:0]  minMult = 7'd2;
  logic [15:0] multWindowLen = 16'd4;
  logic [15:0] emptyLen = 16'd3;
  logic        grandOr;
  logic        multTrig;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  scint_mult_trig dut_i (
    .clk(clk), .rstN(rstN), .topHits(topHits), .botHits(botHits),
    .barMode(barMode), .minMult(minMult), .multWindowLen(multWindowLen),
    .emptyLen(emptyLen), .grandOr(grandOr), .multTrig(multTrig)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [63:0] top;
    logic [63:0] bot;
    logic        expG;
    logic        expT;
  } vec_t;

  localparam logic [63:0] T1 = 64'h8000_0000_0000_0001;
  localparam logic [63:0] B1 = 64'h0000_0000_0000_0001;

  // R1 R2 R6: mode table, 2-bar patterns trigger with minimum 2
  localparam vec_t VECS [10] = '{
    '{2'd0, T1,        64'd0, 1'b0, 1'b0},
    '{2'd0, 64'd0,     B1,    1'b1, 1'b0},
    '{2'd1, T1,        64'd0, 1'b1, 1'b1},
    '{2'd1, 64'd0,     B1,    1'b0, 1'b0},
    '{2'd2, 64'd0,     B1,    1'b1, 1'b0},
    '{2'd2, T1,        B1,    1'b1, 1'b1},
    '{2'd3, 64'h20,    64'h40, 1'b0, 1'b0},
    '{2'd3, 64'h60,    64'h40, 1'b1, 1'b0},
    '{2'd3, 64'h3,     64'h3, 1'b1, 1'b1},
    '{2'd2, 64'd0,     64'd0, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle of hits; g is grandOr before the edge, trigger readable after return
  task automatic cyc(input logic [63:0] t, input logic [63:0] b, output logic g);
    @(negedge clk);
    topHits = t;
    botHits = b;
    #1 g = grandOr;
    @(posedge clk);
    #1;
  endtask

  task automatic quiet(input int n);
    logic g;
    for (int i = 0; i < n; i++) cyc(64'd0, 64'd0, g);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic g;
    repeat (4) @(posedge clk);
    #1;
    // R9: reset state
    check(multTrig == 1'b0, "R9 trig in reset", multTrig, 0);
    check(grandOr == 1'b0, "R9 grandOr in reset", grandOr, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check(multTrig == 1'b0, "R9 trig after reset", multTrig, 0);

    // R3: not armed right after reset, hit restarts quiet count
    cyc(64'h6, 64'd0, g);
    check(multTrig == 1'b0, "R3 unarmed after reset", multTrig, 0);
    quiet(2);
    cyc(64'h6, 64'd0, g);
    check(multTrig == 1'b0, "R3 two quiet cycles too few", multTrig, 0);
    quiet(3);
    cyc(64'h6, 64'd0, g);
    check(multTrig == 1'b1, "R3 armed after three quiet cycles", multTrig, 1);
    quiet(1);
    check(multTrig == 1'b0, "R6 pulse one cycle", multTrig, 0);

    // vector table
    foreach (VECS[k]) begin
      @(negedge clk);
      barMode = VECS[k].mode;
      quiet(10);
      cyc(VECS[k].top, VECS[k].bot, g);
      check(g == VECS[k].expG, $sformatf("R1 R2 vector %0d grandOr", k), g, VECS[k].expG);
      check(multTrig == VECS[k].expT, $sformatf("R1 R6 vector %0d trig", k), multTrig, VECS[k].expT);
    end

    // R5 R4: repeats count once, last window cycle included (min 3)
    @(negedge clk);
    barMode = 2'd2;
    minMult = 7'd3;
    quiet(10);
    cyc(64'd1 << 5, 64'd0, g);
    check(multTrig == 1'b0, "R5 cycle1", multTrig, 0);
    cyc(64'd1 << 5, 64'd0, g);
    check(multTrig == 1'b0, "R5 repeated bar counts once", multTrig, 0);
    cyc((64'd1 << 5) | (64'd1 << 9), 64'd0, g);
    check(multTrig == 1'b0, "R5 two distinct bars", multTrig, 0);
    cyc(64'd0, 64'd1 << 20, g);
    check(multTrig == 1'b1, "R4 third bar on last window cycle", multTrig, 1);

    // R7 R4: third bar one cycle after window close
    quiet(10);
    cyc(64'd1 << 5, 64'd0, g);
    cyc(64'd1 << 5, 64'd0, g);
    cyc(64'd1 << 9, 64'd0, g);
    cyc(64'd0, 64'd0, g);
    check(multTrig == 1'b0, "R7 window closes short", multTrig, 0);
    cyc(64'd1 << 20, 64'd0, g);
    check(multTrig == 1'b0, "R4 hit after window excluded", multTrig, 0);
    quiet(3);
    cyc(64'h0E, 64'd0, g);
    check(multTrig == 1'b1, "R7 rearmed after new quiet period", multTrig, 1);

    // R6: one trigger per window, no retrigger without quiet period
    @(negedge clk);
    minMult = 7'd2;
    quiet(10);
    cyc(64'h6, 64'd0, g);
    check(multTrig == 1'b1, "R6 first trigger", multTrig, 1);
    cyc(64'h18, 64'd0, g);
    check(multTrig == 1'b0, "R6 no second trigger in window", multTrig, 0);
    quiet(2);
    cyc(64'h60, 64'd0, g);
    check(multTrig == 1'b0, "R6 no trigger without quiet period", multTrig, 0);

    // R8: minimum changed mid-window is ignored, then applies
    quiet(10);
    cyc(64'h2, 64'd0, g);
    @(negedge clk);
    minMult = 7'd5;
    cyc(64'h4, 64'd0, g);
    check(multTrig == 1'b1, "R8 old minimum used in open window", multTrig, 1);
    quiet(10);
    cyc(64'h6, 64'd0, g);
    check(multTrig == 1'b0, "R8 new minimum applied after window", multTrig, 0);
    cyc(64'h38, 64'd0, g);
    check(multTrig == 1'b1, "R8 five bars reach new minimum", multTrig, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule